// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home node for a small group of memory blocks that P private caches share. For every block it keeps a full map: one presence bit per cache and one exclusive bit. Caches send Read, ReadEx and Upgrade requests. The controller looks up the block's entry and decides between three outcomes. It can grant at once, it can refuse with a NACK, or it can send an invalidation or downgrade to the current holders and defer the grant until every acknowledgement has arrived.

Messages travel over three valid/ready channels. Requests come in, and grants or NACKs go out to the requester. A single multicast snoop message carries a node mask. Acknowledgements come back one per snooped cache and name only the block. While an entry waits for acknowledgements it is busy, and any request to that block is refused so the requester can retry. Other blocks are still served during this time. The memory data path and the cache controllers lie outside this block.

Top module: `dir_home`

## Requirements
- R1: After reset no response and no snoop message is pending, the block accepts requests, and every entry holds no copies.
- R2: A Read (op 0) to a block that no other cache holds returns an exclusive-data grant (kind 2). The requester is then the only holder, with the exclusive bit set.
- R3: A Read to a block held in shared form by other caches returns a shared-data grant (kind 1) and adds the requester as a holder.
- R4: A Read to a block owned exclusively by another cache sends a downgrade (snoop kind 1) to that owner alone. The shared grant is sent only after the acknowledgement arrives. From then on both caches are shared holders and the exclusive bit is clear.
- R5: A ReadEx (op 1) to a block with other holders sends one invalidation (snoop kind 0) whose mask (bit i = node i) holds exactly those holders. The exclusive-data grant is sent only after as many acknowledgements as there were holders.
- R6: An Upgrade (op 2) from a current holder invalidates the other holders and returns a grant without data (kind 3). An Upgrade from a cache that no longer holds the block is handled as a ReadEx and returns kind 2.
- R7: A request to a busy entry is answered with a NACK (kind 0) and leaves the entry unchanged.
- R8: While one entry is busy, requests to other blocks are served normally.
- R9: A pending response or snoop message keeps its valid and its fields unchanged until it is taken.
- R10: An acknowledgement has priority over a request: req_ready is low whenever ack_valid is high. req_ready is also low while the response slot or the snoop slot is full and not being drained. An acknowledgement to an idle entry has no effect.
- R11: A grant or NACK appears the cycle after the request is accepted. A deferred grant appears the cycle after the final acknowledgement is accepted.
- R12: A Read by the exclusive owner itself returns kind 2 and sends no snoop message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_node | input | $clog2(P) | Requesting cache |
| req_blk | input | $clog2(NB) | Block index |
| req_op | input | 2 | 0 Read, 1 ReadEx, 2 Upgrade |
| ack_valid | input | 1 | Snoop acknowledgement present |
| ack_ready | output | 1 | Acknowledgement accepted |
| ack_blk | input | $clog2(NB) | Block the acknowledgement belongs to |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | 0 NACK, 1 shared data, 2 exclusive data, 3 exclusive without data |
| rsp_node | output | $clog2(P) | Destination cache |
| rsp_blk | output | $clog2(NB) | Block index |
| fwd_valid | output | 1 | Snoop message pending |
| fwd_ready | input | 1 | Snoop message taken |
| fwd_mask | output | P | Target caches, bit i = node i |
| fwd_kind | output | 1 | 0 invalidate, 1 downgrade |
| fwd_blk | output | $clog2(NB) | Block index |

## Verification
A grant, NACK or snoop message for an accepted request is due one cycle after the accepting edge. A deferred grant is due one cycle after the edge that takes the last acknowledgement. The handshake outputs depend only on the inputs of the current cycle. The bench drives inputs just after the falling edge and samples late in the low phase, so each value it compares is the one the next rising edge acts on. A behavioural model steps at every rising edge on those same inputs and predicts valid, content and readiness for the next sample. Directed sequences then check the grants collected at each handshake in order, including the absence of a grant before the final acknowledgement.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_RDEX = 2'd1, OP_UPGR = 2'd2, OP_RSVD = 2'd3} dir_op_e;
  typedef enum logic [1:0] {RSP_NACK = 2'd0, RSP_SHARED = 2'd1, RSP_EXCL = 2'd2, RSP_UPGD = 2'd3} dir_rsp_e;
  localparam logic FWD_INV  = 1'b0;
  localparam logic FWD_DOWN = 1'b1;

  // number of set bits in a holder mask (masks up to 32 caches)
  function automatic int unsigned holder_count(input logic [31:0] m);
    int unsigned c = 0;
    for (int i = 0; i < 32; i++) c += int'(m[i]);
    return c;
  endfunction
endpackage

// File: rtl/dir_decide.sv
module dir_decide import dir_pkg::*; #(
  parameter int P  = 4,
  parameter int NW = 2,
  parameter int CW = 3
) (
  input  logic [P-1:0]  cur_pres,
  input  logic          cur_excl,
  input  logic          cur_busy,
  input  logic [1:0]    op,
  input  logic [NW-1:0] node,
  output logic          fwd_need,
  output logic [P-1:0]  fwd_mask,
  output logic          fwd_kind,
  output logic [CW-1:0] ack_cnt,
  output logic [P-1:0]  nxt_pres,
  output logic          nxt_excl,
  output logic [1:0]    rsp_kind
);
  logic [P-1:0] sel, others;
  logic         holds;

  assign sel    = P'(1) << node;
  assign others = cur_pres & ~sel;
  assign holds  = |(cur_pres & sel);

  always_comb begin
    fwd_need = 1'b0;
    fwd_mask = others;
    fwd_kind = FWD_INV;
    ack_cnt  = '0;
    nxt_pres = cur_pres;
    nxt_excl = cur_excl;
    rsp_kind = RSP_NACK;
    if (!cur_busy) begin
      if (op == OP_RDEX || op == OP_UPGR) begin
        rsp_kind = (op == OP_UPGR && holds) ? RSP_UPGD : RSP_EXCL;
        nxt_pres = sel;
        nxt_excl = 1'b1;
        if (|others) begin
          fwd_need = 1'b1;
          ack_cnt  = CW'(holder_count(32'(others)));
        end
      end else if (cur_excl && |others) begin
        fwd_need = 1'b1;
        fwd_kind = FWD_DOWN;
        ack_cnt  = CW'(1);
        nxt_pres = others | sel;
        nxt_excl = 1'b0;
        rsp_kind = RSP_SHARED;
      end else if (cur_excl) begin
        rsp_kind = RSP_EXCL;
      end else if (!(|others)) begin
        rsp_kind = RSP_EXCL;
        nxt_pres = sel;
        nxt_excl = 1'b1;
      end else begin
        rsp_kind = RSP_SHARED;
        nxt_pres = cur_pres | sel;
      end
    end
  end
endmodule

// File: rtl/dir_entry.sv
module dir_entry #(
  parameter int P  = 4,
  parameter int NW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_busy,
  input  logic [P-1:0]  ld_pres,
  input  logic          ld_excl,
  input  logic [CW-1:0] ld_cnt,
  input  logic [1:0]    ld_kind,
  input  logic [NW-1:0] ld_node,
  input  logic          ack_hit,
  output logic [P-1:0]  pres,
  output logic          excl,
  output logic          busy,
  output logic          fin,
  output logic [1:0]    pend_kind,
  output logic [NW-1:0] pend_node
);
  logic [CW-1:0] cnt;
  logic [P-1:0]  pnd_pres;
  logic          pnd_excl;

  assign fin = busy && ack_hit && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres      <= '0;
      excl      <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      pnd_pres  <= '0;
      pnd_excl  <= 1'b0;
      pend_kind <= '0;
      pend_node <= '0;
    end else if (load) begin
      if (ld_busy) begin
        busy      <= 1'b1;
        cnt       <= ld_cnt;
        pnd_pres  <= ld_pres;
        pnd_excl  <= ld_excl;
        pend_kind <= ld_kind;
        pend_node <= ld_node;
      end else begin
        pres <= ld_pres;
        excl <= ld_excl;
      end
    end else if (ack_hit && busy) begin
      cnt <= cnt - CW'(1);
      if (fin) begin
        busy <= 1'b0;
        pres <= pnd_pres;
        excl <= pnd_excl;
      end
    end
  end
endmodule

// File: rtl/dir_home.sv
module dir_home #(
  parameter int P  = 4,
  parameter int NB = 8,
  localparam int NW = (P > 1) ? $clog2(P) : 1,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  input  logic [1:0]    req_op,
  input  logic          ack_valid,
  output logic          ack_ready,
  input  logic [BW-1:0] ack_blk,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_kind,
  output logic [NW-1:0] rsp_node,
  output logic [BW-1:0] rsp_blk,
  output logic          fwd_valid,
  input  logic          fwd_ready,
  output logic [P-1:0]  fwd_mask,
  output logic          fwd_kind,
  output logic [BW-1:0] fwd_blk
);
  // named events for the checker
  logic slot_free, fwd_free, req_fire, ack_fire;
  logic [NB-1:0]   busy_vec, excl_vec, fin_vec;
  logic [NB*P-1:0] pres_flat;
  logic [P-1:0]    ent_pres [NB];
  logic [1:0]      ent_pk   [NB];
  logic [NW-1:0]   ent_pn   [NB];

  logic          dec_fwd, dec_fkind, dec_excl;
  logic [P-1:0]  dec_mask, dec_pres;
  logic [CW-1:0] dec_cnt;
  logic [1:0]    dec_rsp;

  assign slot_free = !rsp_valid || rsp_ready;
  assign fwd_free  = !fwd_valid || fwd_ready;
  assign ack_ready = slot_free;
  assign req_ready = slot_free && fwd_free && !ack_valid;
  assign req_fire  = req_valid && req_ready;
  assign ack_fire  = ack_valid && ack_ready;

  dir_decide #(.P(P), .NW(NW), .CW(CW)) u_dec (
    .cur_pres(ent_pres[req_blk]), .cur_excl(excl_vec[req_blk]), .cur_busy(busy_vec[req_blk]),
    .op(req_op), .node(req_node),
    .fwd_need(dec_fwd), .fwd_mask(dec_mask), .fwd_kind(dec_fkind), .ack_cnt(dec_cnt),
    .nxt_pres(dec_pres), .nxt_excl(dec_excl), .rsp_kind(dec_rsp)
  );

  for (genvar g = 0; g < NB; g++) begin : g_ent
    dir_entry #(.P(P), .NW(NW), .CW(CW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .load(req_fire && !busy_vec[g] && (req_blk == BW'(g))),
      .ld_busy(dec_fwd), .ld_pres(dec_pres), .ld_excl(dec_excl), .ld_cnt(dec_cnt),
      .ld_kind(dec_rsp), .ld_node(req_node),
      .ack_hit(ack_fire && (ack_blk == BW'(g))),
      .pres(ent_pres[g]), .excl(excl_vec[g]), .busy(busy_vec[g]), .fin(fin_vec[g]),
      .pend_kind(ent_pk[g]), .pend_node(ent_pn[g])
    );
    assign pres_flat[g*P +: P] = ent_pres[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_node  <= '0;
      rsp_blk   <= '0;
    end else if (ack_fire && fin_vec[ack_blk]) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= ent_pk[ack_blk];
      rsp_node  <= ent_pn[ack_blk];
      rsp_blk   <= ack_blk;
    end else if (req_fire && !dec_fwd) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= dec_rsp;
      rsp_node  <= req_node;
      rsp_blk   <= req_blk;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_mask  <= '0;
      fwd_kind  <= 1'b0;
      fwd_blk   <= '0;
    end else if (req_fire && dec_fwd) begin
      fwd_valid <= 1'b1;
      fwd_mask  <= dec_mask;
      fwd_kind  <= dec_fkind;
      fwd_blk   <= req_blk;
    end else if (fwd_ready) begin
      fwd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int P  = 4,
  parameter int NB = 8,
  localparam int NW = (P > 1) ? $clog2(P) : 1,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [NW-1:0] req_node,
  input logic [BW-1:0] req_blk,
  input logic          ack_valid,
  input logic [BW-1:0] ack_blk,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_kind,
  input logic [NW-1:0] rsp_node,
  input logic [BW-1:0] rsp_blk,
  input logic          fwd_valid,
  input logic          fwd_ready,
  input logic [P-1:0]  fwd_mask,
  input logic          fwd_kind,
  input logic [BW-1:0] fwd_blk,
  input logic          req_fire,
  input logic          ack_fire,
  input logic          dec_fwd,
  input logic [NB-1:0] busy_vec,
  input logic [NB-1:0] excl_vec,
  input logic [NB-1:0] fin_vec,
  input logic [NB*P-1:0] pres_flat
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_node) && $stable(rsp_blk));
  // R9
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_mask) && $stable(fwd_kind) && $stable(fwd_blk));
  // R10
  ack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !req_ready);
  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && busy_vec[req_blk] |=> rsp_valid && rsp_kind == 2'd0);
  // R5
  fwd_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && dec_fwd |=> fwd_valid && ((fwd_mask & (P'(1) << $past(req_node))) == '0));
  // R11
  fin_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && fin_vec[ack_blk] |=> rsp_valid && rsp_kind != 2'd0);

  for (genvar i = 0; i < NB; i++) begin : g_one
    // R2
    excl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      excl_vec[i] |-> $countones(pres_flat[i*P +: P]) == 1);
  end
endmodule

bind dir_home dir_home_chk #(.P(P), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_node(req_node), .req_blk(req_blk),
  .ack_valid(ack_valid), .ack_blk(ack_blk),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_mask(fwd_mask), .fwd_kind(fwd_kind), .fwd_blk(fwd_blk),
  .req_fire(req_fire), .ack_fire(ack_fire), .dec_fwd(dec_fwd),
  .busy_vec(busy_vec), .excl_vec(excl_vec), .fin_vec(fin_vec), .pres_flat(pres_flat)
);

// File: tb/tb_dir_home.sv
module tb_dir_home;
  localparam int P = 4, NB = 8, NW = 2, BW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, ack_valid, ack_ready, rsp_valid, rsp_ready, fwd_valid, fwd_ready, fwd_kind;
  logic [NW-1:0] req_node, rsp_node;
  logic [BW-1:0] req_blk, ack_blk, rsp_blk, fwd_blk;
  logic [1:0] req_op, rsp_kind;
  logic [P-1:0] fwd_mask;

  dir_home #(.P(P), .NB(NB)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit run_cmp = 0;
  int rq[$], fq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [P-1:0] m_pres [NB];
  logic [P-1:0] m_pp [NB];
  bit m_excl [NB], m_busy [NB], m_pe [NB];
  int m_cnt [NB], m_pk [NB], m_pn [NB];
  bit m_rv, m_fv;
  int m_rsp, m_fwd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_pres[b] = 0; m_excl[b] = 0; m_busy[b] = 0; m_cnt[b] = 0;
      end
      m_rv = 0; m_fv = 0;
    end else begin
      bit slot, ffree, ackf, reqf;
      slot  = !m_rv || rsp_ready;
      ffree = !m_fv || fwd_ready;
      ackf  = ack_valid && slot;
      reqf  = req_valid && slot && ffree && !ack_valid;
      if (m_rv && rsp_ready) m_rv = 0;
      if (m_fv && fwd_ready) m_fv = 0;
      if (ackf && m_busy[ack_blk]) begin
        m_cnt[ack_blk]--;
        if (m_cnt[ack_blk] == 0) begin
          m_busy[ack_blk] = 0;
          m_pres[ack_blk] = m_pp[ack_blk];
          m_excl[ack_blk] = m_pe[ack_blk];
          m_rv = 1;
          m_rsp = m_pk[ack_blk] * 256 + m_pn[ack_blk] * 16 + int'(ack_blk);
        end
      end
      if (reqf) begin
        int b, n, k, cnt;
        logic [P-1:0] me, oth, np;
        bit ne, holds, fw, fk;
        b = int'(req_blk); n = int'(req_node);
        me = 0; me[n] = 1'b1;
        oth = m_pres[b] & ~me;
        holds = m_pres[b][n];
        fw = 0; fk = 0; cnt = 0; np = m_pres[b]; ne = m_excl[b]; k = 0;
        if (m_busy[b]) k = 0;
        else if (req_op == 2'd1 || req_op == 2'd2) begin
          k = (req_op == 2'd2 && holds) ? 3 : 2;
          np = me; ne = 1;
          if (oth != 0) begin fw = 1; cnt = $countones(oth); end
        end else if (m_excl[b] && oth != 0) begin
          fw = 1; fk = 1; cnt = 1; np = oth | me; ne = 0; k = 1;
        end else if (m_excl[b]) k = 2;
        else if (oth == 0) begin k = 2; np = me; ne = 1; end
        else begin k = 1; np = m_pres[b] | me; end
        if (m_busy[b]) begin
          m_rv = 1; m_rsp = n * 16 + b;
        end else if (fw) begin
          m_fv = 1; m_fwd = int'(oth) * 256 + int'(fk) * 16 + b;
          m_busy[b] = 1; m_cnt[b] = cnt; m_pp[b] = np; m_pe[b] = ne; m_pk[b] = k; m_pn[b] = n;
        end else begin
          m_rv = 1; m_rsp = k * 256 + n * 16 + b;
          m_pres[b] = np; m_excl[b] = ne;
        end
      end
    end
  end

  // late-low-phase comparison and handshake capture
  always @(negedge clk) begin
    #3;
    if (run_cmp) begin
      int ar, af;
      ar = int'(rsp_kind) * 256 + int'(rsp_node) * 16 + int'(rsp_blk);
      af = int'(fwd_mask) * 256 + int'(fwd_kind) * 16 + int'(fwd_blk);
      chk(rsp_valid === m_rv, "R11 rsp_valid timing", int'(rsp_valid), int'(m_rv));
      if (rsp_valid && m_rv) chk(ar == m_rsp, "R11 response fields", ar, m_rsp);
      chk(fwd_valid === m_fv, "R5 fwd_valid timing", int'(fwd_valid), int'(m_fv));
      if (fwd_valid && m_fv) chk(af == m_fwd, "R5 snoop fields", af, m_fwd);
      chk(req_ready === ((!m_rv || rsp_ready) && (!m_fv || fwd_ready) && !ack_valid),
          "R10 req_ready", int'(req_ready), int'((!m_rv || rsp_ready) && (!m_fv || fwd_ready) && !ack_valid));
      chk(ack_ready === (!m_rv || rsp_ready), "R10 ack_ready", int'(ack_ready), int'(!m_rv || rsp_ready));
      if (rsp_valid && rsp_ready) rq.push_back(ar);
      if (fwd_valid && fwd_ready) fq.push_back(af);
    end
  end

  task automatic send(input int n, input int b, input int op);
    @(negedge clk); #1;
    req_valid = 1; req_node = NW'(n); req_blk = BW'(b); req_op = 2'(op);
    #2;
    while (!req_ready) begin @(negedge clk); #3; end
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic ack(input int b);
    @(negedge clk); #1;
    ack_valid = 1; ack_blk = BW'(b);
    #2;
    while (!ack_ready) begin @(negedge clk); #3; end
    @(negedge clk); #1;
    ack_valid = 0;
  endtask

  task automatic want_rsp(input int k, input int n, input int b, input string tag);
    for (int i = 0; i < 30 && rq.size() == 0; i++) begin @(posedge clk); #1; end
    if (rq.size() == 0) chk(0, tag, -1, k * 256 + n * 16 + b);
    else begin
      int a;
      a = rq.pop_front();
      chk(a == k * 256 + n * 16 + b, tag, a, k * 256 + n * 16 + b);
    end
  endtask

  task automatic want_fwd(input int m, input int k, input int b, input string tag);
    for (int i = 0; i < 30 && fq.size() == 0; i++) begin @(posedge clk); #1; end
    if (fq.size() == 0) chk(0, tag, -1, m * 256 + k * 16 + b);
    else begin
      int a;
      a = fq.pop_front();
      chk(a == m * 256 + k * 16 + b, tag, a, m * 256 + k * 16 + b);
    end
  endtask

  initial begin
    #(8 * 50000);
    n_bad++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; ack_valid = 0; req_node = 0; req_blk = 0; req_op = 0; ack_blk = 0;
    rsp_ready = 1; fwd_ready = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    #2;
    chk(rsp_valid == 0, "R1 no response after reset", int'(rsp_valid), 0);
    chk(fwd_valid == 0, "R1 no snoop after reset", int'(fwd_valid), 0);
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    run_cmp = 1;

    send(0, 0, 0); want_rsp(2, 0, 0, "R2 sole reader gets exclusive");
    send(0, 0, 0); want_rsp(2, 0, 0, "R12 owner reread");
    chk(fq.size() == 0, "R12 no snoop on owner reread", fq.size(), 0);

    send(1, 0, 0); want_fwd(4'b0001, 1, 0, "R4 downgrade to owner");
    send(2, 0, 0); want_rsp(0, 2, 0, "R7 busy entry nacks");
    send(2, 1, 0); want_rsp(2, 2, 1, "R8 other block served");
    ack(0); want_rsp(1, 1, 0, "R4 shared grant after ack");

    send(2, 0, 0); want_rsp(1, 2, 0, "R3 shared read");

    send(3, 0, 1); want_fwd(4'b0111, 0, 0, "R5 invalidate holders");
    ack(0); ack(0);
    repeat (3) @(negedge clk);
    chk(rq.size() == 0, "R5 no grant before last ack", rq.size(), 0);
    ack(0); want_rsp(2, 3, 0, "R5 exclusive after all acks");
    send(0, 0, 0); want_fwd(4'b1000, 1, 0, "R4 new owner downgraded");
    ack(0); want_rsp(1, 0, 0, "R4 shared grant to n0");

    send(1, 2, 0); want_rsp(2, 1, 2, "R2 block 2 exclusive");
    send(2, 2, 0); want_fwd(4'b0010, 1, 2, "R4 block 2 downgrade");
    ack(2); want_rsp(1, 2, 2, "R4 block 2 shared");
    send(1, 2, 2); want_fwd(4'b0100, 0, 2, "R6 upgrade invalidates other");
    ack(2); want_rsp(3, 1, 2, "R6 dataless grant");
    send(0, 2, 2); want_fwd(4'b0010, 0, 2, "R6 non-holder upgrade");
    ack(2); want_rsp(2, 0, 2, "R6 non-holder gets data");

    @(negedge clk); #1 rsp_ready = 0;
    send(0, 3, 0);
    repeat (3) @(negedge clk);
    #3;
    chk(rsp_valid == 1, "R9 response held", int'(rsp_valid), 1);
    chk(req_ready == 0, "R10 blocked while slot full", int'(req_ready), 0);
    @(negedge clk); #1 rsp_ready = 1;
    want_rsp(2, 0, 3, "R9 held response content");

    @(negedge clk); #1 fwd_ready = 0;
    send(1, 3, 1);
    repeat (3) @(negedge clk);
    #3;
    chk(fwd_valid == 1, "R9 snoop held", int'(fwd_valid), 1);
    chk(req_ready == 0, "R10 blocked while snoop full", int'(req_ready), 0);
    @(negedge clk); #1 fwd_ready = 1;
    want_fwd(4'b0001, 0, 3, "R9 held snoop content");
    ack(3); want_rsp(2, 1, 3, "R5 block 3 exclusive");

    @(negedge clk); #1;
    ack_valid = 1; ack_blk = 3'd5; req_valid = 1; req_node = 2'd2; req_blk = 3'd6; req_op = 2'd0;
    #2;
    chk(req_ready == 0, "R10 ack has priority", int'(req_ready), 0);
    chk(ack_ready == 1, "R10 ack accepted", int'(ack_ready), 1);
    @(negedge clk); #1 ack_valid = 0;
    #2;
    chk(req_ready == 1, "R10 request resumes", int'(req_ready), 1);
    @(negedge clk); #1 req_valid = 0;
    want_rsp(2, 2, 6, "R10 request after ack");
    send(3, 5, 0); want_rsp(2, 3, 5, "R10 stray ack had no effect");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule